// File: doc/BRIEF.md
# Instrument Status Byte and Service Request Unit

This block holds the 8-bit status byte and the 8-bit service request enable register of a test instrument. It tracks how many messages sit in the response queue and in the error queue, and it raises a service request line when an enabled condition appears. Message storage, command parsing and the bus handshake sit outside this block. They report to it through push and pop strobes for each queue, three summary levels from other status registers, and two read strobes.

Every status byte bit except bit 6 is a live copy of its source and never latches. Bit 6 has two meanings. A status query sees it as the master summary, which is a live OR of the enabled bits. A serial poll sees it as the request-for-service flag. That flag latches on a rising master summary and is cleared only by a poll or by the clear-all input. Each read returns one registered response beat in the cycle after the request. The response interface has no ready signal. The consumer must take a beat whenever `rsp_valid` is high, and nothing is held back.

Top module: `stsrq_status_unit`

## Requirements
- R1: After reset the live status byte is 0x00, `srq` is low, the enable register reads 0x00, and both queue counts are 0.
- R2: Status bits 3, 5 and 7 equal `ques_sum`, `evt_sum` and `oper_sum` in the same cycle with no latching. Bits 0 and 1 read 0.
- R3: The output queue count (default depth 16) rises on a push and falls on a pop. A pop of an empty queue and a push to a full queue are ignored. Status bit 4 is 1 exactly when the count is non-zero.
- R4: The error queue count holds at most 32 entries. A push when it is full is dropped. A push and a pop in the same cycle leave the count unchanged. Status bit 2 is 1 exactly when the count is non-zero.
- R5: Writing the enable register with `sre_wr` takes effect at the next edge and reads back on `sre_value`. Bit 6 of the enable register never contributes to the master summary.
- R6: The master summary is the OR, over bits 0-5 and 7, of each status bit ANDed with its enable bit. It appears on `stat_byte[6]`. A query returns `{rsp_is_poll=0, rsp_data}` one cycle later with bit 6 equal to the master summary, and it changes no state.
- R7: The request flag sets at the clock edge where the master summary is 1 and was 0 at the previous edge. It stays set after the summary falls. `srq` equals the flag.
- R8: A serial poll returns one cycle later with `rsp_is_poll=1` and bit 6 equal to the flag value before the poll, then clears the flag. If a query and a poll are requested together, the poll is served.
- R9: If a poll and a rising master summary fall in the same cycle, the poll returns the old flag value and the flag ends the cycle set.
- R10: `clear_all` zeroes both queue counts and the request flag in one cycle, overriding a push in the same cycle. The enable register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_all | input | 1 | Clears queue counts and request flag |
| sre_wr | input | 1 | Enable register write strobe |
| sre_wdata | input | 8 | Enable register write data |
| oq_push | input | 1 | Output queue message added |
| oq_pop | input | 1 | Output queue message read |
| eq_push | input | 1 | Error queue message added |
| eq_pop | input | 1 | Error queue message read |
| ques_sum | input | 1 | Summary level for bit 3 |
| evt_sum | input | 1 | Event status summary for bit 5 |
| oper_sum | input | 1 | Summary level for bit 7 |
| query_req | input | 1 | Status query request |
| poll_req | input | 1 | Serial poll request |
| stat_byte | output | 8 | Live status byte, bit 6 = master summary |
| sre_value | output | 8 | Enable register contents |
| oq_count | output | clog2(OQ_DEPTH+1) | Output queue occupancy |
| eq_count | output | clog2(EQ_DEPTH+1) | Error queue occupancy |
| srq | output | 1 | Service request line |
| rsp_valid | output | 1 | Response beat valid |
| rsp_is_poll | output | 1 | Beat answers a poll |
| rsp_data | output | 8 | Returned status byte |

## Verification
A wrong occupancy count shows on `stat_byte` bit 2 or 4 only when the count wrongly reaches or leaves zero. The count ports expose it in the cycle after the faulty edge. A request flag that sets late, clears on its own or survives a poll shows on `srq` one edge after the edge in question, and the next poll response carries the wrong bit 6. A lost flag history, where the previous master summary is forgotten, produces a spurious or missing request at the following edge. That is why the bench checks the pins every cycle against an independent model and scores each read response in order.

// File: rtl/stsrq_pkg.sv
package stsrq_pkg;
  localparam int STB_W = 8;

  localparam int BIT_EAV  = 2;
  localparam int BIT_QUES = 3;
  localparam int BIT_MAV  = 4;
  localparam int BIT_EVT  = 5;
  localparam int BIT_SUM6 = 6;
  localparam int BIT_OPER = 7;

  // bits that may contribute to the master summary
  localparam logic [STB_W-1:0] SUM_SRC_MASK = ~(STB_W'(1) << BIT_SUM6);

  typedef struct packed {
    logic             is_poll;
    logic [STB_W-1:0] data;
  } rsp_beat_t;
endpackage

// File: rtl/stsrq_queue_tracker.sv
module stsrq_queue_tracker #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic          not_empty
);
  localparam logic [CW-1:0] FULL_VAL = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          full;

  assign full      = (cnt_q == FULL_VAL);
  assign not_empty = (cnt_q != '0);
  assign count     = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (push && pop) begin
      cnt_d = cnt_q;
    end else if (push && !full) begin
      cnt_d = cnt_q + CW'(1);
    end else if (pop && not_empty) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_VAL); // R4

  AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (cnt_q == FULL_VAL)); // R4

  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && pop && !push && !clr) |=> (cnt_q == '0)); // R3

  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !clr) |=> $stable(cnt_q)); // R4

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/stsrq_enable_reg.sv
module stsrq_enable_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end

  AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q)); // R5
endmodule

// File: rtl/stsrq_service_req.sv
module stsrq_service_req
  import stsrq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             poll,
  input  logic [STB_W-1:0] stb_src,
  input  logic [STB_W-1:0] enable,
  output logic             mss,
  output logic             rqs
);
  logic mss_hist_q;
  logic rqs_q;
  logic rise;

  assign mss  = |(stb_src & enable & SUM_SRC_MASK);
  assign rise = mss && !mss_hist_q;
  assign rqs  = rqs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mss_hist_q <= 1'b0;
      rqs_q      <= 1'b0;
    end else if (clr) begin
      mss_hist_q <= 1'b0;
      rqs_q      <= 1'b0;
    end else begin
      mss_hist_q <= mss;
      if (rise)      rqs_q <= 1'b1;
      else if (poll) rqs_q <= 1'b0;
    end
  end

  AST_RQS_SETS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clr) |=> rqs_q); // R7

  AST_RQS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rqs_q && !poll && !clr) |=> rqs_q); // R7

  AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (poll && !rise && !clr) |=> !rqs_q); // R8

  AST_POLL_RISE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (poll && rise && !clr) |=> rqs_q); // R9

  AST_CLR_DROPS_RQS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rqs_q); // R10
endmodule

// File: rtl/stsrq_status_unit.sv
module stsrq_status_unit
  import stsrq_pkg::*;
#(
  parameter int OQ_DEPTH = 16,
  parameter int EQ_DEPTH = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear_all,
  input  logic                          sre_wr,
  input  logic [7:0]                    sre_wdata,
  input  logic                          oq_push,
  input  logic                          oq_pop,
  input  logic                          eq_push,
  input  logic                          eq_pop,
  input  logic                          ques_sum,
  input  logic                          evt_sum,
  input  logic                          oper_sum,
  input  logic                          query_req,
  input  logic                          poll_req,
  output logic [7:0]                    stat_byte,
  output logic [7:0]                    sre_value,
  output logic [$clog2(OQ_DEPTH+1)-1:0] oq_count,
  output logic [$clog2(EQ_DEPTH+1)-1:0] eq_count,
  output logic                          srq,
  output logic                          rsp_valid,
  output logic                          rsp_is_poll,
  output logic [7:0]                    rsp_data
);
  localparam int OQ_CW = $clog2(OQ_DEPTH + 1);
  localparam int EQ_CW = $clog2(EQ_DEPTH + 1);

  logic             oq_avail;
  logic             eq_avail;
  logic [STB_W-1:0] live_src;
  logic             mss;
  logic             rqs;
  rsp_beat_t        beat_q;
  logic             beat_vld_q;

  stsrq_queue_tracker #(.DEPTH(OQ_DEPTH), .CW(OQ_CW)) u_oq_trk (
    .clk(clk), .rst_n(rst_n), .clr(clear_all),
    .push(oq_push), .pop(oq_pop),
    .count(oq_count), .not_empty(oq_avail)
  );

  stsrq_queue_tracker #(.DEPTH(EQ_DEPTH), .CW(EQ_CW)) u_eq_trk (
    .clk(clk), .rst_n(rst_n), .clr(clear_all),
    .push(eq_push), .pop(eq_pop),
    .count(eq_count), .not_empty(eq_avail)
  );

  stsrq_enable_reg #(.W(STB_W)) u_sre (
    .clk(clk), .rst_n(rst_n), .wr(sre_wr), .wdata(sre_wdata), .q(sre_value)
  );

  // live summary bits; bit 6 is supplied per read kind
  always_comb begin
    live_src           = '0;
    live_src[BIT_EAV]  = eq_avail;
    live_src[BIT_QUES] = ques_sum;
    live_src[BIT_MAV]  = oq_avail;
    live_src[BIT_EVT]  = evt_sum;
    live_src[BIT_OPER] = oper_sum;
  end

  stsrq_service_req u_srq (
    .clk(clk), .rst_n(rst_n), .clr(clear_all), .poll(poll_req),
    .stb_src(live_src), .enable(sre_value), .mss(mss), .rqs(rqs)
  );

  always_comb begin
    stat_byte           = live_src;
    stat_byte[BIT_SUM6] = mss;
  end

  assign srq = rqs;

  // one response beat per read; a poll wins over a simultaneous query
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_vld_q <= 1'b0;
      beat_q     <= '0;
    end else begin
      beat_vld_q <= query_req || poll_req;
      if (poll_req) begin
        beat_q.is_poll          <= 1'b1;
        beat_q.data             <= live_src;
        beat_q.data[BIT_SUM6]   <= rqs;
      end else if (query_req) begin
        beat_q.is_poll          <= 1'b0;
        beat_q.data             <= stat_byte;
      end
    end
  end

  assign rsp_valid   = beat_vld_q;
  assign rsp_is_poll = beat_q.is_poll;
  assign rsp_data    = beat_q.data;

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (query_req || poll_req) |=> rsp_valid); // R6

  AST_POLL_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |=> (rsp_valid && rsp_is_poll)); // R8

  AST_QUERY_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (query_req && !poll_req) |=> (rsp_valid && !rsp_is_poll)); // R6

  AST_CLEAR_KEEPS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_all && !sre_wr) |=> $stable(sre_value)); // R10

  AST_NO_IDLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !(query_req || poll_req) |=> !rsp_valid); // R6
endmodule

// File: tb/stsrq_status_unit_tb_top.sv
module stsrq_status_unit_tb_top;
  localparam int OQ_DEPTH = 16;
  localparam int EQ_DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       clear_all = 0, sre_wr = 0;
  logic [7:0] sre_wdata = 0;
  logic       oq_push = 0, oq_pop = 0, eq_push = 0, eq_pop = 0;
  logic       ques_sum = 0, evt_sum = 0, oper_sum = 0;
  logic       query_req = 0, poll_req = 0;
  logic [7:0] stat_byte, sre_value, rsp_data;
  logic [4:0] oq_count;
  logic [5:0] eq_count;
  logic       srq, rsp_valid, rsp_is_poll;

  stsrq_status_unit #(.OQ_DEPTH(OQ_DEPTH), .EQ_DEPTH(EQ_DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
    .sre_wr(sre_wr), .sre_wdata(sre_wdata),
    .oq_push(oq_push), .oq_pop(oq_pop), .eq_push(eq_push), .eq_pop(eq_pop),
    .ques_sum(ques_sum), .evt_sum(evt_sum), .oper_sum(oper_sum),
    .query_req(query_req), .poll_req(poll_req),
    .stat_byte(stat_byte), .sre_value(sre_value),
    .oq_count(oq_count), .eq_count(eq_count), .srq(srq),
    .rsp_valid(rsp_valid), .rsp_is_poll(rsp_is_poll), .rsp_data(rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // requirement model
  int         m_oq = 0, m_eq = 0;
  logic [7:0] m_sre = 0;
  logic       m_rqs = 0, m_hist = 0, m_mss_now;

  function automatic logic [7:0] m_live();
    return {oper_sum, 1'b0, evt_sum, (m_oq != 0), ques_sum, (m_eq != 0), 2'b00};
  endfunction

  function automatic logic m_mss();
    return |(m_live() & m_sre & 8'hBF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_oq = 0; m_eq = 0; m_sre = 0; m_rqs = 0; m_hist = 0;
    end else begin
      m_mss_now = m_mss();
      if (sre_wr) m_sre = sre_wdata;
      if (clear_all) begin
        m_oq = 0; m_eq = 0; m_rqs = 0; m_hist = 0;
      end else begin
        if (oq_push && !oq_pop && m_oq < OQ_DEPTH) m_oq++;
        else if (oq_pop && !oq_push && m_oq > 0) m_oq--;
        if (eq_push && !eq_pop && m_eq < EQ_DEPTH) m_eq++;
        else if (eq_pop && !eq_push && m_eq > 0) m_eq--;
        if (m_mss_now && !m_hist) m_rqs = 1;
        else if (poll_req) m_rqs = 0;
        m_hist = m_mss_now;
      end
    end
  end

  // scoreboard
  logic [8:0] exp_q[$];

  always @(negedge clk) begin
    logic [7:0] lv;
    logic [8:0] e;
    #2;
    if (rst_n && !done) begin
      lv = m_live();
      lv[6] = m_mss();
      chk("R7 srq follows flag", srq, m_rqs);
      chk("R6 live status byte", stat_byte, lv);
      chk("R3 output queue count", oq_count, m_oq);
      chk("R4 error queue count", eq_count, m_eq);
      chk("R5 enable readback", sre_value, m_sre);
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk("R6 unexpected response", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(e[8] ? "R8 poll response" : "R6 query response", {rsp_is_poll, rsp_data}, e);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input bit poll, input bit both);
    logic [7:0] e;
    e = m_live();
    e[6] = poll ? m_rqs : m_mss();
    exp_q.push_back({poll, e});
    query_req = !poll || both;
    poll_req  = poll;
    cyc();
    query_req = 0;
    poll_req  = 0;
  endtask

  task automatic wr_sre(input logic [7:0] v);
    sre_wr = 1; sre_wdata = v; cyc(); sre_wr = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 status byte", stat_byte, 8'h00);
    chk("R1 srq", srq, 0);
    chk("R1 enable", sre_value, 8'h00);
    chk("R1 counts", {oq_count, eq_count}, 0);

    // R2 direct summaries, no latching
    ques_sum = 1; cyc(); chk("R2 bit3", stat_byte, 8'h08);
    ques_sum = 0; evt_sum = 1; cyc(); chk("R2 bit5 only", stat_byte, 8'h20);
    evt_sum = 0; oper_sum = 1; cyc(); chk("R2 bit7 only", stat_byte, 8'h80);
    oper_sum = 0; cyc(); chk("R2 released", stat_byte, 8'h00);

    // R3 output queue
    oq_pop = 1; cyc(); oq_pop = 0; chk("R3 pop on empty", oq_count, 0);
    oq_push = 1; repeat (3) cyc(); oq_push = 0;
    chk("R3 mav set", stat_byte[4], 1);
    oq_pop = 1; repeat (3) cyc(); oq_pop = 0;
    chk("R3 mav clears when empty", stat_byte[4], 0);
    oq_push = 1; repeat (OQ_DEPTH + 2) cyc(); oq_push = 0;
    chk("R3 full saturates", oq_count, OQ_DEPTH);
    oq_pop = 1; repeat (OQ_DEPTH) cyc(); oq_pop = 0;

    // R4 error queue
    eq_push = 1; repeat (EQ_DEPTH + 3) cyc(); eq_push = 0;
    chk("R4 saturates at 32", eq_count, 32);
    chk("R4 eav set", stat_byte[2], 1);
    eq_push = 1; eq_pop = 1; cyc(); eq_push = 0; eq_pop = 0;
    chk("R4 push+pop unchanged", eq_count, 32);
    eq_pop = 1; repeat (EQ_DEPTH) cyc(); eq_pop = 0;
    chk("R4 eav clears", stat_byte[2], 0);

    // R5 bit 6 of the enable is ignored
    wr_sre(8'h40);
    evt_sum = 1; ques_sum = 1; oper_sum = 1; oq_push = 1; eq_push = 1; cyc();
    oq_push = 0; eq_push = 0; cyc();
    chk("R5 bit6 enable ignored", stat_byte[6], 0);
    chk("R5 no request", srq, 0);
    evt_sum = 0; ques_sum = 0; oper_sum = 0;
    oq_pop = 1; eq_pop = 1; cyc(); oq_pop = 0; eq_pop = 0;

    // R6/R7 request via MAV
    wr_sre(8'h10);
    rd(0, 0);
    oq_push = 1; cyc(); oq_push = 0;
    chk("R6 master summary up", stat_byte[6], 1);
    cyc();
    chk("R7 srq raised", srq, 1);
    rd(0, 0); rd(0, 0);
    chk("R6 query leaves flag", srq, 1);
    oq_pop = 1; cyc(); oq_pop = 0;
    chk("R7 flag held after summary falls", srq, 1);
    rd(1, 0);
    chk("R8 poll clears flag", srq, 0);
    rd(1, 0);

    // R8 query and poll together: poll served
    oq_push = 1; cyc(); oq_push = 0; cyc();
    rd(1, 1);
    chk("R8 poll wins over query", srq, 0);
    oq_pop = 1; cyc(); oq_pop = 0;

    // R9 poll coinciding with a rising summary
    wr_sre(8'h20);
    evt_sum = 1; cyc();
    evt_sum = 0; cyc();
    evt_sum = 1; rd(1, 0);
    chk("R9 flag stays set (was set)", srq, 1);
    rd(1, 0);
    chk("R9 later poll clears", srq, 0);
    evt_sum = 0; cyc();
    evt_sum = 1; rd(1, 0);
    chk("R9 flag set (was clear)", srq, 1);
    evt_sum = 0; rd(1, 0);

    // R10 clear-all
    wr_sre(8'h14);
    oq_push = 1; eq_push = 1; repeat (4) cyc(); oq_push = 0; eq_push = 0;
    cyc();
    chk("R10 precondition srq", srq, 1);
    clear_all = 1; oq_push = 1; eq_push = 1; cyc();
    clear_all = 0; oq_push = 0; eq_push = 0;
    chk("R10 output count cleared", oq_count, 0);
    chk("R10 error count cleared", eq_count, 0);
    chk("R10 flag cleared", srq, 0);
    chk("R10 enable kept", sre_value, 8'h14);
    cyc();
    chk("R10 no re-request", srq, 0);

    repeat (3) cyc();
    chk("R6 all responses seen", exp_q.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule